// File: doc/BRIEF.md
# UART Interrupt Event Generator

This block turns the status lines of a UART and its receive and transmit DMA buffers into one interrupt request. Each status condition becomes an event source with its own sticky pending bit. A per-source enable mask decides which pending bits may raise the request line. Software acknowledges a source by writing a one to its bit on the acknowledge port.

There are three kinds of source. The first kind is the three FIFO conditions: transmitter idle, transmit FIFO has space, and receive FIFO holds data. A mode input sets how these trigger. In edge mode a 0-to-1 change latches the pending bit. In level mode the pending bit follows the live status. The second kind is the DMA buffers: a buffer completes when its active flag falls from 1 to 0. The third kind is the parity, framing and overrun error pulses, which set their bits directly.

Top module: `uart_irq_gen`

## Requirements
- R1: When reset is released, every pending bit, every enable bit and the request output are 0.
- R2: With `level_mode_i` low, a 0-to-1 change on tx idle, tx free or rx valid sets pending bit 0, 1 or 2 (in that order) at the next clock edge. The bit then stays set until it is acknowledged.
- R3: With `level_mode_i` high, pending bits 0 to 2 equal the tx idle, tx free and rx valid inputs sampled at the previous edge. An acknowledge write has no effect on these bits.
- R4: For B buffers per direction, a 1-to-0 change on transmit buffer-active flag b sets pending bit 3+b. A 1-to-0 change on receive flag b sets bit 3+B+b. A rising or steady flag sets nothing.
- R5: Each cycle that the parity, framing or overrun pulse is high sets pending bit 3+2B, 4+2B or 5+2B respectively.
- R6: An acknowledge write clears each edge-type pending bit whose data bit is 1. Bits written as 0 keep their value.
- R7: When an event and an acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R8: An enable write loads the enable mask at the next edge. Pending bits are set whether or not they are enabled.
- R9: `irq_o` is a register. It goes high one edge after any pending bit and its enable bit are both 1, and low one edge after no such pair exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_mode_i | input | 1 | 1: FIFO sources are level-triggered; 0: rising-edge |
| tx_idle_i | input | 1 | Transmit FIFO empty and shifter drained |
| tx_free_i | input | 1 | Transmit FIFO not full |
| rx_valid_i | input | 1 | Receive FIFO not empty |
| tx_dma_act_i | input | DMA_BUFS | Transmit DMA buffer-active flags |
| rx_dma_act_i | input | DMA_BUFS | Receive DMA buffer-active flags |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| ovr_err_i | input | 1 | Receive overrun pulse |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | NSRC | New enable mask |
| ack_wr_i | input | 1 | Acknowledge write strobe |
| ack_wdata_i | input | NSRC | Write-one-to-clear acknowledge mask |
| pending_o | output | NSRC | Pending flags |
| enable_o | output | NSRC | Current enable mask |
| irq_o | output | 1 | Registered aggregate request |

## Verification
The bench builds the block with DMA_BUFS = 2, which gives ten sources. At that size the random enable and acknowledge masks reach every bit position often. The transmit and receive DMA groups each have two flags, so a mix-up between buffers A and B or between the two directions shows up as a wrong bit index. The mode input toggles during the random run, so the bench also covers edge-to-level and level-to-edge changes while FIFO status is high.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int FIFO_SRCS = 3;
  localparam int ERR_SRCS  = 3;

  function automatic int src_count(input int bufs);
    return FIFO_SRCS + 2 * bufs + ERR_SRCS;
  endfunction

  function automatic int tx_dma_base();
    return FIFO_SRCS;
  endfunction

  function automatic int rx_dma_base(input int bufs);
    return FIFO_SRCS + bufs;
  endfunction

  function automatic int err_base(input int bufs);
    return FIFO_SRCS + 2 * bufs;
  endfunction

  function automatic logic rise_det(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction

  function automatic logic fall_det(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // next value of one pending bit: tracked bits copy the level,
  // others are sticky with set taking priority over clear
  function automatic logic pend_bit_next(input logic cur, input logic set,
                                         input logic clr, input logic track,
                                         input logic level);
    if (track) return level;
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/uart_irq_detect.sv
module uart_irq_detect
  import uart_irq_pkg::*;
#(
  parameter int DMA_BUFS = 2,
  localparam int NSRC = src_count(DMA_BUFS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 level_mode_i,
  input  logic [FIFO_SRCS-1:0] fifo_stat_i,
  input  logic [DMA_BUFS-1:0]  tx_act_i,
  input  logic [DMA_BUFS-1:0]  rx_act_i,
  input  logic [ERR_SRCS-1:0]  err_i,
  output logic [NSRC-1:0]      set_o,
  output logic [NSRC-1:0]      track_o,
  output logic [NSRC-1:0]      track_val_o
);
  localparam int TXB = tx_dma_base();
  localparam int RXB = rx_dma_base(DMA_BUFS);
  localparam int ERB = err_base(DMA_BUFS);

  logic [FIFO_SRCS-1:0] fifo_prev_q;
  logic [DMA_BUFS-1:0]  tx_prev_q;
  logic [DMA_BUFS-1:0]  rx_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_prev_q <= '0;
      tx_prev_q   <= '0;
      rx_prev_q   <= '0;
    end else begin
      fifo_prev_q <= fifo_stat_i;
      tx_prev_q   <= tx_act_i;
      rx_prev_q   <= rx_act_i;
    end
  end

  for (genvar k = 0; k < FIFO_SRCS; k++) begin : g_fifo
    assign set_o[k]       = !level_mode_i && rise_det(fifo_prev_q[k], fifo_stat_i[k]);
    assign track_o[k]     = level_mode_i;
    assign track_val_o[k] = fifo_stat_i[k];
  end

  for (genvar b = 0; b < DMA_BUFS; b++) begin : g_dma
    assign set_o[TXB+b]       = fall_det(tx_prev_q[b], tx_act_i[b]);
    assign set_o[RXB+b]       = fall_det(rx_prev_q[b], rx_act_i[b]);
    assign track_o[TXB+b]     = 1'b0;
    assign track_o[RXB+b]     = 1'b0;
    assign track_val_o[TXB+b] = 1'b0;
    assign track_val_o[RXB+b] = 1'b0;

    // R4
    tx_rise_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_act_i[b]) |-> !set_o[TXB+b]);
    // R4
    rx_rise_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_act_i[b]) |-> !set_o[RXB+b]);
  end

  for (genvar k = 0; k < ERR_SRCS; k++) begin : g_err
    assign set_o[ERB+k]       = err_i[k];
    assign track_o[ERB+k]     = 1'b0;
    assign track_val_o[ERB+k] = 1'b0;
  end
endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
  import uart_irq_pkg::*;
#(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] track_i,
  input  logic [NSRC-1:0] track_val_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] clr_data_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] pend_q;

  assign clr_mask = clr_wr_i ? clr_data_i : '0;
  assign pend_o   = pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_bit_next(pend_q[i], set_i[i], clr_mask[i],
                                             track_i[i], track_val_i[i]);
    end

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!track_i[i] && pend_q[i] && !(clr_wr_i && clr_data_i[i])) |=> pend_q[i]);
    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!track_i[i] && !set_i[i] && clr_wr_i && clr_data_i[i]) |=> !pend_q[i]);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!track_i[i] && set_i[i]) |=> pend_q[i]);
    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      track_i[i] |=> (pend_q[i] == $past(track_val_i[i])));
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] en_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q;
  logic            irq_q;
  logic            any_live;

  assign any_live = |(pend_i & en_q);
  assign en_o     = en_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= en_wdata_i;
      irq_q <= any_live;
    end
  end

  // R8
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> (en_q == $past(en_wdata_i)));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_i & en_q)) |=> irq_q);
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_i & en_q)) |=> !irq_q);
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int DMA_BUFS = 2,
  localparam int NSRC = src_count(DMA_BUFS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                level_mode_i,
  input  logic                tx_idle_i,
  input  logic                tx_free_i,
  input  logic                rx_valid_i,
  input  logic [DMA_BUFS-1:0] tx_dma_act_i,
  input  logic [DMA_BUFS-1:0] rx_dma_act_i,
  input  logic                par_err_i,
  input  logic                frm_err_i,
  input  logic                ovr_err_i,
  input  logic                en_wr_i,
  input  logic [NSRC-1:0]     en_wdata_i,
  input  logic                ack_wr_i,
  input  logic [NSRC-1:0]     ack_wdata_i,
  output logic [NSRC-1:0]     pending_o,
  output logic [NSRC-1:0]     enable_o,
  output logic                irq_o
);
  localparam int ERB = err_base(DMA_BUFS);

  logic [NSRC-1:0] set_w;
  logic [NSRC-1:0] track_w;
  logic [NSRC-1:0] track_val_w;
  logic [NSRC-1:0] pend_w;

  uart_irq_detect #(.DMA_BUFS(DMA_BUFS)) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .level_mode_i (level_mode_i),
    .fifo_stat_i  ({rx_valid_i, tx_free_i, tx_idle_i}),
    .tx_act_i     (tx_dma_act_i),
    .rx_act_i     (rx_dma_act_i),
    .err_i        ({ovr_err_i, frm_err_i, par_err_i}),
    .set_o        (set_w),
    .track_o      (track_w),
    .track_val_o  (track_val_w)
  );

  uart_irq_pending #(.NSRC(NSRC)) u_pending (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (set_w),
    .track_i     (track_w),
    .track_val_i (track_val_w),
    .clr_wr_i    (ack_wr_i),
    .clr_data_i  (ack_wdata_i),
    .pend_o      (pend_w)
  );

  uart_irq_mask #(.NSRC(NSRC)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .pend_i     (pend_w),
    .en_o       (enable_o),
    .irq_o      (irq_o)
  );

  assign pending_o = pend_w;

  // R5
  par_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_i |=> pending_o[ERB]);
  // R5
  ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err_i |=> pending_o[ERB+2]);
  // R2
  idle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode_i && set_w[0]) |=> pending_o[0]);
endmodule

// File: tb/uart_irq_gen_bench.sv
`timescale 1ns/1ps
module uart_irq_gen_bench;
  localparam int BUFS = 2;
  localparam int N    = 3 + 2 * BUFS + 3;
  localparam int TXB  = 3;
  localparam int RXB  = 3 + BUFS;
  localparam int ERB  = 3 + 2 * BUFS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            lvl = 0, tx_idle = 0, tx_free = 0, rx_valid = 0;
  logic [BUFS-1:0] txa = '0, rxa = '0;
  logic            par = 0, frm = 0, ovr = 0;
  logic            en_wr = 0, ack_wr = 0;
  logic [N-1:0]    en_data = '0, ack_data = '0;
  logic [N-1:0]    pending_o, enable_o;
  logic            irq_o;

  uart_irq_gen #(.DMA_BUFS(BUFS)) u_uart_irq_gen (
    .clk(clk), .rst_n(rst_n), .level_mode_i(lvl),
    .tx_idle_i(tx_idle), .tx_free_i(tx_free), .rx_valid_i(rx_valid),
    .tx_dma_act_i(txa), .rx_dma_act_i(rxa),
    .par_err_i(par), .frm_err_i(frm), .ovr_err_i(ovr),
    .en_wr_i(en_wr), .en_wdata_i(en_data),
    .ack_wr_i(ack_wr), .ack_wdata_i(ack_data),
    .pending_o(pending_o), .enable_o(enable_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [N-1:0]    m_pend = '0, m_en = '0;
  logic            m_irq = 0;
  logic [2:0]      m_fprev = '0;
  logic [BUFS-1:0] m_tprev = '0, m_rprev = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] events_now();
    logic [N-1:0] h = '0;
    logic [2:0] f = {rx_valid, tx_free, tx_idle};
    for (int k = 0; k < 3; k++)
      if (!lvl && f[k] && !m_fprev[k]) h[k] = 1'b1;
    for (int b = 0; b < BUFS; b++) begin
      if (m_tprev[b] && !txa[b]) h[TXB+b] = 1'b1;
      if (m_rprev[b] && !rxa[b]) h[RXB+b] = 1'b1;
    end
    h[ERB] = par; h[ERB+1] = frm; h[ERB+2] = ovr;
    return h;
  endfunction

  task automatic model_clock();
    logic [N-1:0] nxt;
    nxt = m_pend;
    if (ack_wr) nxt = nxt & ~ack_data;
    nxt = nxt | events_now();
    if (lvl) nxt[2:0] = {rx_valid, tx_free, tx_idle};
    m_irq  = |(m_pend & m_en);
    m_pend = nxt;
    if (en_wr) m_en = en_data;
    m_fprev = {rx_valid, tx_free, tx_idle};
    m_tprev = txa;
    m_rprev = rxa;
  endtask

  task automatic compare_all();
    chk(lvl ? "R3" : "R2", 32'(pending_o[2:0]), 32'(m_pend[2:0]));
    chk("R4", 32'(pending_o[ERB-1:TXB]), 32'(m_pend[ERB-1:TXB]));
    chk("R5", 32'(pending_o[N-1:ERB]), 32'(m_pend[N-1:ERB]));
    chk("R8", 32'(enable_o), 32'(m_en));
    chk("R9", 32'(irq_o), 32'(m_irq));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    par = 0; frm = 0; ovr = 0; en_wr = 0; ack_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(pending_o), 0);
    chk("R1", 32'(enable_o), 0);
    chk("R1", 32'(irq_o), 0);

    // R5 parity pulse sets its bit
    par = 1; cyc();
    chk("R5", 32'(pending_o[ERB]), 1);
    // R7 event and ack of same bit together
    ack_wr = 1; ack_data = N'(1) << ERB; cyc();
    chk("R7", 32'(pending_o[ERB]), 1);
    // R6 zero bits of ack keep value
    par = 0; ack_data = ~(N'(1) << ERB); cyc();
    chk("R6", 32'(pending_o[ERB]), 1);
    // R6 one bit clears
    ack_data = N'(1) << ERB; cyc();
    chk("R6", 32'(pending_o[ERB]), 0);
    quiet();

    // R8 disabled source still pends, no request
    frm = 1; cyc(); frm = 0; cyc();
    chk("R8", 32'(pending_o[ERB+1]), 1);
    chk("R8", 32'(irq_o), 0);
    // R9 enable then registered request
    en_wr = 1; en_data = N'(1) << (ERB + 1); cyc(); en_wr = 0;
    chk("R8", 32'(enable_o), 32'(N'(1) << (ERB + 1)));
    chk("R9", 32'(irq_o), 0);
    cyc();
    chk("R9", 32'(irq_o), 1);
    ack_wr = 1; ack_data = N'(1) << (ERB + 1); cyc(); ack_wr = 0;
    cyc();
    chk("R9", 32'(irq_o), 0);

    // R2 edge-mode rising edge of rx valid is sticky
    rx_valid = 1; cyc(); cyc();
    chk("R2", 32'(pending_o[2]), 1);
    rx_valid = 0; cyc();
    chk("R2", 32'(pending_o[2]), 1);
    ack_wr = 1; ack_data = 'b100; cyc(); ack_wr = 0;

    // R3 level mode follows status, ack ignored
    lvl = 1; tx_idle = 1; cyc();
    chk("R3", 32'(pending_o[0]), 1);
    ack_wr = 1; ack_data = '1; cyc(); ack_wr = 0;
    chk("R3", 32'(pending_o[0]), 1);
    tx_idle = 0; cyc();
    chk("R3", 32'(pending_o[0]), 0);
    lvl = 0;

    // R4 rising DMA flag no event, falling sets
    txa[1] = 1; cyc();
    chk("R4", 32'(pending_o[TXB+1]), 0);
    txa[1] = 0; cyc();
    chk("R4", 32'(pending_o[TXB+1]), 1);
    rxa[0] = 1; cyc(); rxa[0] = 0; cyc();
    chk("R4", 32'(pending_o[RXB]), 1);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if (c % 700 == 699) lvl = ~lvl;
      if ($urandom_range(3) == 0) tx_idle = ~tx_idle;
      if ($urandom_range(3) == 0) tx_free = ~tx_free;
      if ($urandom_range(3) == 0) rx_valid = ~rx_valid;
      for (int b = 0; b < BUFS; b++) begin
        if ($urandom_range(3) == 0) txa[b] = ~txa[b];
        if ($urandom_range(3) == 0) rxa[b] = ~rxa[b];
      end
      par = ($urandom_range(15) == 0);
      frm = ($urandom_range(15) == 0);
      ovr = ($urandom_range(15) == 0);
      en_wr = ($urandom_range(19) == 0);
      en_data = N'($urandom);
      ack_wr = ($urandom_range(5) == 0);
      ack_data = N'($urandom);
      cyc();
    end
    quiet();
    cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule